// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. Software reads and writes three 32-bit registers: control/status, the live count, and the timeout limit. While enabled, the count advances either on every clock or once per 256 clocks when the prescaler is selected. When the count matches the limit, the block latches a timeout flag and raises its reset-request output. Software keeps the system alive by writing a service key to the counter offset, which returns the count to zero.

Software cannot change the configuration by accident. A key must first be written to the counter offset. In wide-key mode the key is one 32-bit word. In split-key mode it is two 16-bit halves, written back to back. A successful key opens a short window, and the unlocked status bit reads 1 for as long as the window lasts. One configuration write to the control or timeout register is then accepted, and that write closes the window. The window also closes by itself after `WIN_CYC` cycles if no configuration write arrives. After each accepted write, a reconfiguration-complete bit reads 0 for `DONE_LAT` cycles and then returns to 1.

The key logic is a three-state machine:
- `KS_LOCKED` is the reset state. A valid wide key, or a valid first half when split keys are selected, moves it to `KS_OPEN` or `KS_HALF`. This happens only while the allow-update bit is set.
- From `KS_HALF`, the next write to the counter offset moves to `KS_OPEN` if it carries the second half. Any other value moves back to `KS_LOCKED`.
- `KS_OPEN` returns to `KS_LOCKED` on an accepted configuration write or when the window expires.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, control/status reads 0x0000_2420 (wide keys, allow-update, reconfiguration complete), the count reads 0, the timeout reads `TOV_RST`, and rst_req is 0.
- R2: The registers sit at byte offsets 0x0 (control/status), 0x4 (count/keys) and 0x8 (timeout). The control/status bits are:
  - bit 14: timeout flag
  - bit 13: wide-key mode
  - bit 12: prescaler select
  - bit 11: unlocked
  - bit 10: reconfiguration complete
  - bits 9:8: clock select
  - bit 7: enable
  - bit 5: allow-update
  - bit 1: run in wait mode
  - bit 0: run in stop mode
  - All other bits read 0.
- R3: With bit 13 set, writing 0xD928_C520 to offset 0x4 makes bit 11 read 1 from the next cycle. A timeout or control write is then accepted.
- R4: With bit 13 clear, the 32-bit key is refused. Unlocking needs 0x0000_C520 and then 0x0000_D928 as consecutive writes to offset 0x4. Any other value in between aborts the sequence and leaves bit 11 at 0.
- R5: While bit 5 is 0, every unlock key is refused and configuration writes are ignored.
- R6: While locked, writes to offsets 0x0 and 0x8 leave the stored configuration and timeout unchanged. Bits 14, 11 and 10 of written data never alter stored configuration fields.
- R7: One accepted configuration write relocks the block (bit 11 reads 0 next cycle). Without such a write, bit 11 stays 1 for exactly `WIN_CYC` cycles.
- R8: After an accepted configuration write, bit 10 reads 0 for `DONE_LAT` cycles and then 1. The count and prescaler restart from zero.
- R9: Writing 0xB480_A602 to offset 0x4 makes the count read 0 on the next cycle, whether locked or not.
- R10: When enabled, the count rises by 1 per clock with bit 12 clear, or by 1 per 256 clocks with bit 12 set. When disabled, it holds.
- R11: When the count equals the timeout on an advance, the count returns to 0, and bit 14 and rst_req become 1. They stay 1 until bit 14 is written with 1 at offset 0x0; this clear works while locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| rst_req | output | 1 | Reset request, high while the timeout flag is set |

## Verification
The unlock machine is tried with four key patterns:
- a correct wide key;
- a split key with a foreign value between its halves;
- a clean split pair;
- keys offered after allow-update was cleared.

Comparing these separates a working abort path from one that merely stays half-open. Window closing is checked at the exact cycle count, which tells a single-write relock apart from the timed expiry. The count is sampled a precise number of cycles after a service key, both with and without the prescaler, so an off-by-one in the divider or the compare shows up as a wrong value. A cycle-level model compares every output on every clock throughout.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    localparam int DW       = 32;
    localparam int OFS_CTRL = 0;
    localparam int OFS_CNT  = 4;
    localparam int OFS_TOV  = 8;

    localparam logic [DW-1:0] KEY_UNLK_W  = 32'hD928_C520;
    localparam logic [DW-1:0] KEY_UNLK_LO = 32'h0000_C520;
    localparam logic [DW-1:0] KEY_UNLK_HI = 32'h0000_D928;
    localparam logic [DW-1:0] KEY_SERVICE = 32'hB480_A602;

    localparam int B_FLAG = 14;
    localparam int B_WIDE = 13;
    localparam int B_PRE  = 12;
    localparam int B_OPEN = 11;
    localparam int B_DONE = 10;
    localparam int B_CSEL = 8;
    localparam int B_EN   = 7;
    localparam int B_UPD  = 5;
    localparam int B_WAIT = 1;
    localparam int B_STOP = 0;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;

    typedef struct packed {
        logic       wide;
        logic       pre;
        logic [1:0] csel;
        logic       en;
        logic       upd;
        logic       wt;
        logic       stp;
    } wdk_cfg_t;
endpackage

// File: rtl/wdk_keyfsm.sv
module wdk_keyfsm
    import wdk_pkg::*;
#(
    parameter int WIN_CYC = 16,
    localparam int WW = $clog2(WIN_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cnt,
    input  logic          wr_cfg,
    input  logic [DW-1:0] wdata,
    input  logic          wide,
    input  logic          upd,
    output logic          unlocked,
    output logic          commit
);
    key_state_e    st_q, st_d;
    logic [WW-1:0] win_q, win_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= KS_LOCKED;
            win_q <= '0;
        end else begin
            st_q  <= st_d;
            win_q <= win_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        win_d = win_q;
        unique case (st_q)
            KS_LOCKED: begin
                win_d = '0;
                if (wr_cnt && upd) begin
                    if (wide && wdata == KEY_UNLK_W)
                        st_d = KS_OPEN;
                    else if (!wide && wdata == KEY_UNLK_LO)
                        st_d = KS_HALF;
                end
            end
            KS_HALF: begin
                win_d = '0;
                if (wr_cnt)
                    st_d = (wdata == KEY_UNLK_HI) ? KS_OPEN : KS_LOCKED;
            end
            KS_OPEN: begin
                if (wr_cfg)
                    st_d = KS_LOCKED;
                else if (win_q == WW'(WIN_CYC - 1))
                    st_d = KS_LOCKED;
                else
                    win_d = win_q + 1'b1;
            end
            default: st_d = KS_LOCKED;
        endcase
    end

    always_comb begin
        unlocked = (st_q == KS_OPEN);
        commit   = unlocked && wr_cfg;
    end
endmodule

// File: rtl/wdk_timebase.sv
module wdk_timebase #(
    parameter int CW    = 32,
    parameter int PRE_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          en,
    input  logic          pre,
    input  logic [CW-1:0] tov,
    output logic [CW-1:0] cnt,
    output logic          expire
);
    logic [PRE_W-1:0] pc_q;
    logic [CW-1:0]    cnt_q;
    logic             tick;

    assign tick   = !pre || (pc_q == '1);
    assign expire = en && !restart && tick && (cnt_q == tov);
    assign cnt    = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            cnt_q <= '0;
        end else if (restart) begin
            pc_q  <= '0;
            cnt_q <= '0;
        end else if (en) begin
            pc_q <= pc_q + 1'b1;
            if (tick)
                cnt_q <= (cnt_q == tov) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdk_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter int          WIN_CYC  = 16,
    parameter int          DONE_LAT = 2,
    parameter int          PRE_W    = 8,
    parameter logic [31:0] TOV_RST  = 32'd1000,
    localparam int LW = $clog2(DONE_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              rst_req
);
    wdk_cfg_t      cfg_q;
    logic [DW-1:0] tov_q;
    logic [DW-1:0] cnt;
    logic [LW-1:0] lat_q;
    logic          flag_q;
    logic          wr_ctrl, wr_cnt, wr_tov, wr_cfg;
    logic          unlocked, commit, refresh, expire, done;

    assign wr_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
    assign wr_cnt  = wr_en && (addr == ADDR_W'(OFS_CNT));
    assign wr_tov  = wr_en && (addr == ADDR_W'(OFS_TOV));
    assign wr_cfg  = wr_ctrl || wr_tov;
    assign refresh = wr_cnt && (wr_data == KEY_SERVICE);
    assign done    = (lat_q == '0);

    wdk_keyfsm #(.WIN_CYC(WIN_CYC)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cnt   (wr_cnt),
        .wr_cfg   (wr_cfg),
        .wdata    (wr_data),
        .wide     (cfg_q.wide),
        .upd      (cfg_q.upd),
        .unlocked (unlocked),
        .commit   (commit)
    );

    wdk_timebase #(.CW(DW), .PRE_W(PRE_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (commit || refresh),
        .en      (cfg_q.en),
        .pre     (cfg_q.pre),
        .tov     (tov_q),
        .cnt     (cnt),
        .expire  (expire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '{wide: 1'b1, pre: 1'b0, csel: 2'b00, en: 1'b0,
                        upd: 1'b1, wt: 1'b0, stp: 1'b0};
            tov_q  <= TOV_RST;
            lat_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (commit && wr_ctrl) begin
                cfg_q.wide <= wr_data[B_WIDE];
                cfg_q.pre  <= wr_data[B_PRE];
                cfg_q.csel <= wr_data[B_CSEL +: 2];
                cfg_q.en   <= wr_data[B_EN];
                cfg_q.upd  <= wr_data[B_UPD];
                cfg_q.wt   <= wr_data[B_WAIT];
                cfg_q.stp  <= wr_data[B_STOP];
            end
            if (commit && wr_tov)
                tov_q <= wr_data;
            if (commit)
                lat_q <= LW'(DONE_LAT);
            else if (!done)
                lat_q <= lat_q - 1'b1;
            if (expire)
                flag_q <= 1'b1;
            else if (wr_ctrl && wr_data[B_FLAG])
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(OFS_CTRL)) begin
            rd_data[B_FLAG]      = flag_q;
            rd_data[B_WIDE]      = cfg_q.wide;
            rd_data[B_PRE]       = cfg_q.pre;
            rd_data[B_OPEN]      = unlocked;
            rd_data[B_DONE]      = done;
            rd_data[B_CSEL +: 2] = cfg_q.csel;
            rd_data[B_EN]        = cfg_q.en;
            rd_data[B_UPD]       = cfg_q.upd;
            rd_data[B_WAIT]      = cfg_q.wt;
            rd_data[B_STOP]      = cfg_q.stp;
        end else if (addr == ADDR_W'(OFS_CNT)) begin
            rd_data = cnt;
        end else if (addr == ADDR_W'(OFS_TOV)) begin
            rd_data = tov_q;
        end
    end

    assign rst_req = flag_q;
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wr_data,
    input logic              unlocked,
    input logic              commit,
    input logic              done,
    input logic              flag,
    input logic              expire,
    input logic              upd,
    input logic              en,
    input logic [31:0]       cnt,
    input logic [31:0]       tov
);
    logic wr_cnt_a;
    assign wr_cnt_a = wr_en && (addr == ADDR_W'(4));

    a_r6_locked_tov_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8) && !unlocked) |=> $stable(tov));

    a_r7_write_relocks: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !unlocked);

    a_r8_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !done);

    a_r9_service_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt_a && wr_data == 32'hB480_A602) |=> (cnt == 32'd0));

    a_r5_unlock_needs_upd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(upd));

    a_r10_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_cnt_a && !commit) |=> $stable(cnt));

    a_r11_flag_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(en));

    a_r11_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0) && wr_data[14] && !expire) |=> !flag);
endmodule

bind wdog_keyed wdk_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .unlocked (unlocked),
    .commit   (commit),
    .done     (done),
    .flag     (flag_q),
    .expire   (expire),
    .upd      (cfg_q.upd),
    .en       (cfg_q.en),
    .cnt      (cnt),
    .tov      (tov_q)
);

// File: tb/sim_wdog_keyed.sv
module sim_wdog_keyed;
    localparam int WIN = 8;
    localparam int LAT = 3;
    localparam logic [31:0] TRST = 32'd1000;
    localparam logic [31:0] K_W    = 32'hD928_C520;
    localparam logic [31:0] K_LO   = 32'h0000_C520;
    localparam logic [31:0] K_HI   = 32'h0000_D928;
    localparam logic [31:0] K_SERV = 32'hB480_A602;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic        rst_req;

    int  n_run = 0;
    int  n_fail = 0;
    bit  fin = 1'b0;

    always #2 clk = ~clk;

    wdog_keyed #(.ADDR_W(4), .WIN_CYC(WIN), .DONE_LAT(LAT), .PRE_W(8), .TOV_RST(TRST)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(we),
        .wr_data(wdata), .rd_data(rd_data), .rst_req(rst_req)
    );

    // behavioural reference
    int          m_st, m_win, m_rc, m_pc;
    bit          m_flag, m_wide, m_pre, m_en, m_upd, m_wt, m_sp;
    bit [1:0]    m_csel;
    logic [31:0] m_tov, m_cnt;
    bit          m_wc, m_wcfg, m_cm, m_rf, m_tk, m_ex;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_win = 0; m_rc = 0; m_pc = 0; m_flag = 0;
            m_wide = 1; m_pre = 0; m_csel = 0; m_en = 0; m_upd = 1; m_wt = 0; m_sp = 0;
            m_tov = TRST; m_cnt = 0;
        end else begin
            m_wc   = we && addr == 4'd4;
            m_wcfg = we && (addr == 4'd0 || addr == 4'd8);
            m_cm   = (m_st == 2) && m_wcfg;
            m_rf   = m_wc && wdata == K_SERV;
            m_tk   = !m_pre || m_pc == 255;
            m_ex   = m_en && !m_cm && !m_rf && m_tk && m_cnt == m_tov;
            if (m_cm || m_rf) begin
                m_cnt = 0; m_pc = 0;
            end else if (m_en) begin
                m_pc = (m_pc + 1) % 256;
                if (m_tk) m_cnt = (m_cnt == m_tov) ? 32'd0 : m_cnt + 32'd1;
            end
            if (m_ex) m_flag = 1;
            else if (we && addr == 4'd0 && wdata[14]) m_flag = 0;
            if (m_cm) m_rc = LAT;
            else if (m_rc > 0) m_rc = m_rc - 1;
            case (m_st)
                0: begin
                    m_win = 0;
                    if (m_wc && m_upd) begin
                        if (m_wide && wdata == K_W) m_st = 2;
                        else if (!m_wide && wdata == K_LO) m_st = 1;
                    end
                end
                1: if (m_wc) m_st = (wdata == K_HI) ? 2 : 0;
                default: begin
                    if (m_wcfg || m_win == WIN - 1) m_st = 0;
                    else m_win = m_win + 1;
                end
            endcase
            if (m_cm && addr == 4'd0) begin
                m_wide = wdata[13]; m_pre = wdata[12]; m_csel = wdata[9:8];
                m_en = wdata[7]; m_upd = wdata[5]; m_wt = wdata[1]; m_sp = wdata[0];
            end
            if (m_cm && addr == 4'd8) m_tov = wdata;
        end
    end

    function automatic logic [31:0] mread(input logic [3:0] a);
        logic [31:0] v = '0;
        if (a == 4'd0) begin
            v[14] = m_flag; v[13] = m_wide; v[12] = m_pre; v[11] = (m_st == 2);
            v[10] = (m_rc == 0); v[9:8] = m_csel; v[7] = m_en; v[5] = m_upd;
            v[1] = m_wt; v[0] = m_sp;
        end else if (a == 4'd4) v = m_cnt;
        else if (a == 4'd8) v = m_tov;
        return v;
    endfunction

    always @(posedge clk) begin
        #1;
        if (rst_n && !fin) begin
            n_run++;
            if (rd_data !== mread(addr)) begin
                n_fail++;
                if (addr == 4'd0) $display("FAIL R2 model ctrl act=%h exp=%h", rd_data, mread(addr));
                else if (addr == 4'd4) $display("FAIL R10 model count act=%h exp=%h", rd_data, mread(addr));
                else $display("FAIL R6 model timeout act=%h exp=%h", rd_data, mread(addr));
            end
            n_run++;
            if (rst_req !== m_flag) begin
                n_fail++;
                $display("FAIL R11 model rst_req act=%b exp=%b", rst_req, m_flag);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; we = 1'b1; wdata = d;
        @(negedge clk); we = 1'b0; wdata = '0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic look(input logic [3:0] a, input logic [31:0] exp,
                        input logic [31:0] mask, input string tag);
        addr = a; #1;
        n_run++;
        if ((rd_data & mask) !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h act=%h exp=%h", tag, a, rd_data & mask, exp);
        end
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic run();
        tick(3); rst_n = 1'b1;
        // R1 reset values
        look(4'd0, 32'h0000_2420, '1, "R1 ctrl reset");
        look(4'd4, 32'd0, '1, "R1 count reset");
        look(4'd8, TRST, '1, "R1 timeout reset");
        chk_bit(rst_req, 1'b0, "R1 rst_req reset");
        // R6 locked write ignored
        wr(4'd8, 32'h55);
        look(4'd8, TRST, '1, "R6 locked timeout write");
        // R3 wide unlock, R7 relock, R8 done latency
        wr(4'd4, K_W);
        look(4'd0, 32'h800, 32'h800, "R3 unlocked after wide key");
        wr(4'd8, 32'd20);
        look(4'd0, 32'h0, 32'hC00, "R7 R8 relock and busy");
        look(4'd8, 32'd20, '1, "R3 timeout accepted");
        tick(2);
        look(4'd0, 32'h0, 32'h400, "R8 still busy");
        tick(1);
        look(4'd0, 32'h400, 32'h400, "R8 done");
        // R7 window expiry
        wr(4'd4, K_W);
        tick(WIN - 1);
        look(4'd0, 32'h800, 32'h800, "R7 window last cycle");
        tick(1);
        look(4'd0, 32'h0, 32'h800, "R7 window closed");
        wr(4'd8, 32'd99);
        look(4'd8, 32'd20, '1, "R6 write after window");
        // R6 status bits in written data
        wr(4'd4, K_W);
        wr(4'd0, 32'h0000_6CA0);
        look(4'd0, 32'h0000_20A0, 32'hFFFF_FBFF, "R6 status bits not stored");
        // R9 / R10
        wr(4'd4, K_SERV);
        look(4'd4, 32'd0, '1, "R9 service zeroes count");
        tick(5);
        look(4'd4, 32'd5, '1, "R10 count per clock");
        // R11 timeout
        for (int i = 0; i < 100 && !rst_req; i++) @(negedge clk);
        chk_bit(rst_req, 1'b1, "R11 rst_req on timeout");
        look(4'd0, 32'h4000, 32'h4000, "R11 flag set");
        look(4'd4, 32'd0, '1, "R11 count wraps");
        wr(4'd0, 32'h0000_4000);
        look(4'd0, 32'h0000_24A0, '1, "R11 flag cleared while locked");
        chk_bit(rst_req, 1'b0, "R11 rst_req cleared");
        // R4 split keys
        wr(4'd4, K_W);
        wr(4'd0, 32'h0000_00A0);
        tick(4);
        wr(4'd4, K_W);
        look(4'd0, 32'h0, 32'h800, "R4 wide key refused");
        wr(4'd4, K_LO); wr(4'd4, 32'h1234); wr(4'd4, K_HI);
        look(4'd0, 32'h0, 32'h800, "R4 aborted sequence");
        wr(4'd4, K_LO); wr(4'd4, K_HI);
        look(4'd0, 32'h800, 32'h800, "R4 split unlock");
        wr(4'd8, 32'd2);
        // R10 prescaler
        wr(4'd4, K_LO); wr(4'd4, K_HI);
        wr(4'd0, 32'h0000_10A0);
        wr(4'd4, K_SERV);
        tick(255);
        look(4'd4, 32'd0, '1, "R10 prescaled 255 clocks");
        tick(1);
        look(4'd4, 32'd1, '1, "R10 prescaled 256 clocks");
        // R5 allow-update cleared
        wr(4'd4, K_LO); wr(4'd4, K_HI);
        wr(4'd0, 32'h0);
        wr(4'd0, 32'h0000_4000);
        tick(10);
        look(4'd4, 32'd0, '1, "R10 disabled holds");
        wr(4'd4, K_LO); wr(4'd4, K_HI);
        look(4'd0, 32'h0, 32'h800, "R5 unlock refused");
        wr(4'd8, 32'd7);
        look(4'd8, 32'd2, '1, "R5 timeout kept");
        look(4'd0, 32'h0000_0400, '1, "R2 final ctrl layout");
    endtask

    initial begin
        fork
            begin run(); end
            begin
                repeat (150000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog act=hung exp=finished");
            end
        join_any
        fin = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule